// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM whose data pins are shared between reading and writing. The host issues single-word requests (address, write data, read/write flag) over a valid/ready port. The controller turns each request into a sequence of active-low chip-select, write-strobe and output-enable levels. Read data comes back with a one-cycle valid pulse.

All memory timing limits are given as nanosecond parameters together with the clock period. They are converted to whole clock-cycle counts by rounding up. The converted counts are:

- the read access window,
- the write pulse length,
- the select-to-strobe-release interval,
- the minimum write cycle, and
- a bus turnaround gap.

The turnaround gap keeps the controller's data drivers off until the memory has had time to release the shared bus.

Writes are controlled by the write strobe, and output-enable is held inactive for the whole write. Because of this the memory never drives the bus while the controller does. Every strobe and the drive enable comes straight from a flip-flop. The address and write data are captured when a request is accepted and held until the cycle ends.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, select, write strobe and output enable are all high, the drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read accepted on a clock edge gives, from the next cycle, select low, output enable low, write strobe high and `mem_addr` equal to the request address. This lasts for a window of 4 cycles (the rounded-up maximum of 35 ns cycle time and 15 ns enable access at a 10 ns clock). `rsp_valid` rises 4 cycles after the first window cycle.
- R3: `mem_din` is sampled on the edge that ends the read window and presented on `rsp_rdata` together with a `rsp_valid` pulse exactly one cycle long, with one response per accepted read.
- R4: `req_ready` is low whenever select is low, and a request is taken only on an edge where `req_valid` and `req_ready` are both high.
- R5: During a write the output enable stays high, and the write strobe is low only while select is low.
- R6: The write strobe low pulse lasts at least 2 cycles (20 ns), and `mem_dout` holds the request's write data, unchanged, for the whole pulse.
- R7: Select is low for at least 3 cycles (25 ns) up to the write strobe's rising edge, and a write cycle keeps select low for at least 4 cycles (35 ns).
- R8: The drive enable rises only after output enable has been high for at least 2 whole cycles (15 ns worst-case release time).
- R9: The drive enable is high exactly while the write strobe is low, so it falls on the same edge on which the strobe rises.
- R10: `mem_addr` does not change while select stays low.
- R11: A read keeps select low for at least 4 cycles (35 ns read cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address pins |
| mem_e_n | output | 1 | Active-low chip select |
| mem_w_n | output | 1 | Active-low write strobe |
| mem_g_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Data the controller drives onto the shared bus |
| mem_dout_en | output | 1 | Enable for the controller's bus drivers |
| mem_din | input | 8 | Data read from the shared bus |

## Verification
The bench's behavioural memory returns a poison byte until output enable and select have been low on a steady address for the full access window. A controller that samples one cycle early therefore returns wrong data. The bench issues a write directly after a read, which stresses the turnaround gap: a design that drives the bus too soon is caught by the count of cycles with output enable high before the drive enable rises. It measures every write strobe pulse, the select time up to the strobe's rise, and whole-cycle lengths, so a shortened pulse or a missing recovery cycle fails. Reads of never-written and overwritten locations show whether a write committed the wrong address or data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC
    } ctrl_st_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_span_timer.sv
module sram_span_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Loaded with a phase length on entry; 'last' marks the phase's final cycle.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic g_n,
    output logic bus_free
);

    localparam int CW = $clog2(TURN_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // cnt_q = number of earlier cycles output enable has been high (saturating).
    always_comb begin
        if (!g_n)                          cnt_d = '0;
        else if (cnt_q == CW'(TURN_CYC))   cnt_d = cnt_q;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(TURN_CYC);
        else        cnt_q <= cnt_d;
    end

    // The current cycle counts too: the drivers turn on at the end of it.
    assign bus_free = g_n && (int'(cnt_q) >= TURN_CYC - 1);

    AST_FREE_NEEDS_G_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(g_n) || (TURN_CYC <= 1)); // R8

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 35,
    parameter int T_OE_NS   = 15,
    parameter int T_WP_NS   = 20,
    parameter int T_DS_NS   = 15,
    parameter int T_AW_NS   = 25,
    parameter int T_WC_NS   = 35,
    parameter int T_TURN_NS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_e_n,
    output logic              mem_w_n,
    output logic              mem_g_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int RD_CYC   = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int WP_CYC   = imax(1, imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                                           ns_to_cyc(T_AW_NS, CLK_NS) - 1));
    localparam int REC_CYC  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - 1 - WP_CYC);
    localparam int TURN_CYC = imax(1, ns_to_cyc(T_TURN_NS, CLK_NS));
    localparam int MAX_CYC  = imax(RD_CYC, imax(WP_CYC, REC_CYC));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_st_e          st;
        logic              e_n;
        logic              w_n;
        logic              g_n;
        logic              dout_en;
        logic              rsp_valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t RST_VAL = '{st: ST_IDLE, e_n: 1'b1, w_n: 1'b1, g_n: 1'b1,
                                  dout_en: 1'b0, rsp_valid: 1'b0,
                                  addr: '0, wdata: '0, rdata: '0};

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;
    logic             bus_free;

    sram_span_timer #(.CNT_W(TMR_W)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .g_n      (r_q.g_n),
        .bus_free (bus_free)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.e_n   = 1'b0;
                    if (req_write) begin
                        r_d.st = ST_WR_SETUP;
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.g_n  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(RD_CYC);
                    end
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    r_d.rdata     = mem_din;
                    r_d.rsp_valid = 1'b1;
                    r_d.e_n       = 1'b1;
                    r_d.g_n       = 1'b1;
                    r_d.st        = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (bus_free) begin
                    r_d.w_n     = 1'b0;
                    r_d.dout_en = 1'b1;
                    r_d.st      = ST_WR_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(WP_CYC);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    r_d.w_n     = 1'b1;
                    r_d.dout_en = 1'b0;
                    r_d.st      = ST_WR_REC;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(REC_CYC);
                end
            end
            ST_WR_REC: begin
                if (tmr_last) begin
                    r_d.e_n = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_rdata   = r_q.rdata;
    assign mem_addr    = r_q.addr;
    assign mem_e_n     = r_q.e_n;
    assign mem_w_n     = r_q.w_n;
    assign mem_g_n     = r_q.g_n;
    assign mem_dout    = r_q.wdata;
    assign mem_dout_en = r_q.dout_en;

    AST_G_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_w_n |-> mem_g_n); // R5
    AST_W_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_w_n |-> !mem_e_n); // R5
    AST_DRIVE_TRACKS_W: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en == !mem_w_n); // R9
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> mem_g_n && $past(mem_g_n)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_e_n && $past(!mem_e_n)) |-> $stable(mem_addr)); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout)); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_e_n |-> !req_ready); // R4
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RD_WIN     = 4;   // R2 window / R11 minimum
    localparam int TURN_MIN   = 2;   // R8
    localparam int WP_MIN     = 2;   // R6
    localparam int AW_MIN     = 3;   // R7
    localparam int WC_MIN     = 4;   // R7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mem_din = 8'hEE;
    logic        req_ready, rsp_valid, mem_e_n, mem_w_n, mem_g_n, mem_dout_en;
    logic [7:0]  rsp_rdata, mem_dout;
    logic [14:0] mem_addr;

    sram_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_e_n(mem_e_n), .mem_w_n(mem_w_n), .mem_g_n(mem_g_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Behavioural memory: truth-table and interval checks, delayed read data.
    logic [7:0] dmem [int];
    int  e_cnt = 0, w_cnt = 0, g_cnt = 100, acc_cnt = 0;
    logic e_p = 1, w_p = 1, den_p = 0;
    logic [14:0] a_p = '0;
    logic [7:0]  d_p = '0;
    bit d_chg = 0, was_write = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_din = 8'hEE;
        end else begin
            if (!mem_w_n) begin
                chk(mem_g_n && !mem_e_n, "R5", "select/enable during W low",
                    {mem_e_n, mem_g_n}, 2'b01);
                chk(mem_dout_en, "R9", "drive enable during W low", mem_dout_en, 1);
            end else if (mem_dout_en) begin
                chk(0, "R9", "drive enable with W high", 1, 0);
            end
            if (mem_dout_en && !den_p)
                chk(g_cnt >= TURN_MIN && mem_g_n, "R8", "G-high cycles before drive",
                    g_cnt, TURN_MIN);
            if (!mem_e_n && !e_p && mem_addr != a_p)
                chk(0, "R10", "address moved while selected", mem_addr, a_p);
            if (!mem_w_n && !w_p && mem_dout != d_p) d_chg = 1;
            if (mem_w_n && !w_p) begin
                chk(w_cnt >= WP_MIN, "R6", "W pulse cycles", w_cnt, WP_MIN);
                chk(!d_chg, "R6", "data stable over pulse", d_chg, 0);
                chk(e_cnt >= AW_MIN, "R7", "select cycles before W rise", e_cnt, AW_MIN);
                dmem[int'(a_p)] = d_p;
                was_write = 1;
                d_chg = 0;
            end
            if (mem_e_n && !e_p) begin
                if (was_write) chk(e_cnt >= WC_MIN, "R7", "write cycle length", e_cnt, WC_MIN);
                else           chk(e_cnt >= RD_WIN, "R11", "read cycle length", e_cnt, RD_WIN);
                was_write = 0;
            end
            acc_cnt = (!mem_e_n && !mem_g_n && mem_w_n && (acc_cnt == 0 || mem_addr == a_p))
                      ? acc_cnt + 1 : 0;
            e_cnt = mem_e_n ? 0 : e_cnt + 1;
            w_cnt = mem_w_n ? 0 : w_cnt + 1;
            g_cnt = mem_g_n ? g_cnt + 1 : 0;
            if (acc_cnt >= RD_WIN)
                mem_din = dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 8'h00;
            else
                mem_din = 8'hEE;
            e_p = mem_e_n; w_p = mem_w_n; den_p = mem_dout_en;
            a_p = mem_addr; d_p = mem_dout;
        end
    end

    // Scoreboard
    logic [7:0] exp_q [$];
    int         lat_q [$];
    logic [7:0] shadow [int];
    bit rsp_p = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (rsp_p) chk(0, "R3", "valid longer than one cycle", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "response with no read pending", 1, 0);
                end else begin
                    logic [7:0] e;
                    int l;
                    e = exp_q.pop_front();
                    l = lat_q.pop_front();
                    chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
                    chk(cyc - l == RD_WIN, "R2", "window-to-valid cycles", cyc - l, RD_WIN);
                end
            end
            rsp_p = rsp_valid;
        end
    end

    task automatic send(input bit wr, input logic [14:0] a, input logic [7:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R4", "ready low in cycle", req_ready, 0);
        if (wr) begin
            shadow[int'(a)] = d;
            chk(!mem_e_n && mem_g_n && mem_w_n && mem_addr == a, "R5",
                "write setup strobes", {mem_e_n, mem_w_n, mem_g_n}, 3'b011);
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
            lat_q.push_back(cyc);
            chk(!mem_e_n && !mem_g_n && mem_w_n && mem_addr == a, "R2",
                "read strobes", {mem_e_n, mem_w_n, mem_g_n}, 3'b010);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_e_n && mem_w_n && mem_g_n && !mem_dout_en && req_ready && !rsp_valid,
            "R1", "reset outputs",
            {mem_e_n, mem_w_n, mem_g_n, mem_dout_en, req_ready, rsp_valid}, 6'b111010);
        rst_n = 1;
        @(negedge clk);
        chk(mem_e_n && req_ready, "R1", "idle after reset", {mem_e_n, req_ready}, 2'b11);
        chk(!rsp_valid, "R4", "no response without request", rsp_valid, 0);
        send(1, 15'h0000, 8'hA5);
        send(1, 15'h7FFF, 8'h5A);
        send(1, 15'h1234, 8'h3C);
        send(0, 15'h0000, 8'h00);
        send(1, 15'h4321, 8'hFF);   // write right after read: turnaround
        send(0, 15'h7FFF, 8'h00);
        send(0, 15'h1234, 8'h00);
        send(0, 15'h0ABC, 8'h00);   // never written
        send(1, 15'h1234, 8'h00);   // overwrite
        send(0, 15'h1234, 8'h00);
        send(0, 15'h4321, 8'h00);
        for (int i = 0; i < 8; i++)
            send(1, 15'((i * 16'h0F0F) & 16'h7FFF), 8'(i * 37 + 1));
        for (int i = 7; i >= 0; i--) begin
            send(0, 15'((i * 16'h0F0F) & 16'h7FFF), 8'h00);
            send(1, 15'h2000 + 15'(i), 8'(255 - i));
        end
        for (int i = 0; i < 8; i++) send(0, 15'h2000 + 15'(i), 8'h00);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "reads left unanswered", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired: actual hung expected done");
        report();
    end

endmodule